// File: doc/BRIEF.md
# LFSR Reseeding Scan Pattern Decompressor

This block turns a short stored seed into a complete deterministic scan test pattern. It contains a K-stage linear feedback shift register with a fixed feedback polynomial. A pattern begins with a start strobe. The register is then cleared, and a partial seed of S bits (S < K) is shifted in serially, least significant bit first. The stages that receive no seed bit stay at zero. This fixed fill rule is what allows a test cube with don't-care positions to be solved into a seed over GF(2).

Once the seed is in place, the register steps freely for L cycles, where L is the scan chain length and may be larger than K. Each step produces one bit on the scan-in output, and a scan enable is high for exactly those cycles. A one-cycle done pulse then closes the pattern, and the block returns to idle ready for the next seed. Seed storage, response capture and compaction belong to neighbouring blocks.

Top module: `lfsr_reseed_dcmp`

## Requirements
- R1: After a synchronous active-high reset, the block is idle with scan_en = 0, done = 0 and scan_out = 0. This also holds when reset arrives in the middle of a pattern.
- R2: A start pulse in idle begins a pattern: one clear cycle, then seed loading. A start pulse while a pattern is in progress, or in the done cycle, is ignored.
- R3: During loading, a seed bit is taken only on cycles where seed_valid is high, so loading can stall. Exactly S bits are taken, the first one received being seed bit 0. seed_valid during the clear cycle, the shift phase or idle is ignored.
- R4: When shifting starts, stage i holds seed bit i for i < S, and stages S..K-1 are zero, whatever the previous pattern left behind.
- R5: scan_en rises in the cycle after the S-th seed bit is taken and stays high for exactly L consecutive cycles. In shift cycle j (counting from 0), scan_out equals stream bit a(j).
- R6: The stream obeys a(n+K) = XOR of a(n+i) over every i whose bit is set in TAPS, with a(i) equal to the initial content of stage i for i < K.
- R7: done is high for exactly one cycle, the cycle right after the last shift cycle, with scan_en low. The block is idle in the next cycle.
- R8: A chain length L larger than K is supported. The bit stream continues the recurrence for all L bits.
- R9: With K = 3 and TAPS = 3'b101, the recurrence is a(n+3) = a(n) XOR a(n+2). Seed stages (a1,a0) = (1,0) give the stream 0,1,0,0,1,1,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a pattern (accepted in idle only) |
| seed_valid | input | 1 | Qualifies seed_bit during loading |
| seed_bit | input | 1 | Serial seed bit, least significant first |
| scan_out | output | 1 | Scan-in bit for the chain (stage 0) |
| scan_en | output | 1 | High during the L shift cycles |
| done | output | 1 | One-cycle pulse when the pattern is complete |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:

- Seeds of all zeros and all ones: a wrong tap or a stray feedback bit would make the stream drift away from the recurrence.
- Patterns that follow a pattern leaving ones in the upper stages: a missing clear would leak those ones into the new stream.
- Seed bits with stalls between them, and seed_valid raised during the clear cycle: a loader that counted cycles instead of valid bits would misplace every bit.
- start and seed_valid toggled throughout the shift phase: restarting or reloading there would break the stream.
- Shift runs much longer than K, and a reset in the middle of a shift: off-by-one counters would show a wrong scan_en length or a misplaced done pulse.

// File: rtl/lfsr_dcmp_pkg.sv
package lfsr_dcmp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_LOAD,
        OP_STEP
    } reg_op_e;

endpackage

// File: rtl/lfsr_dcmp_ctrl.sv
module lfsr_dcmp_ctrl
    import lfsr_dcmp_pkg::*;
#(
    parameter int S = 10,
    parameter int L = 40
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    seed_valid,
    output reg_op_e op,
    output logic    scan_en,
    output logic    done
);
    localparam int MAXN = (S > L) ? S : L;
    localparam int CW   = $clog2(MAXN + 1);
    localparam logic [CW-1:0] LAST_SEED  = CW'(S - 1);
    localparam logic [CW-1:0] LAST_SHIFT = CW'(L - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        op  = OP_HOLD;
        case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st = ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                op      = OP_CLEAR;
                c_d.cnt = '0;
                c_d.st  = ST_LOAD;
            end
            ST_LOAD: begin
                if (seed_valid) begin
                    op = OP_LOAD;
                    if (c_q.cnt == LAST_SEED) begin
                        c_d.cnt = '0;
                        c_d.st  = ST_SHIFT;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                op = OP_STEP;
                if (c_q.cnt == LAST_SHIFT) begin
                    c_d.cnt = '0;
                    c_d.st  = ST_DONE;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            ST_DONE: begin
                c_d.st = ST_IDLE;
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.st  <= ST_IDLE;
            c_q.cnt <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign scan_en = (c_q.st == ST_SHIFT);
    assign done    = (c_q.st == ST_DONE);

endmodule

// File: rtl/lfsr_dcmp_core.sv
module lfsr_dcmp_core
    import lfsr_dcmp_pkg::*;
#(
    parameter int           K    = 16,
    parameter int           S    = 10,
    parameter logic [K-1:0] TAPS = K'(16'h002D)
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_op_e      op,
    input  logic         seed_bit,
    output logic [K-1:0] stages
);
    logic [K-1:0] st_d, st_q;
    logic [K-1:0] load_nxt;
    logic [K-1:0] step_nxt;
    logic         fb;

    assign fb = ^(st_q & TAPS);

    for (genvar i = 0; i < K; i++) begin : g_stage
        if (i < S) begin : g_seeded
            if (i == S - 1) begin : g_entry
                assign load_nxt[i] = seed_bit;
            end else begin : g_pass
                assign load_nxt[i] = st_q[i+1];
            end
        end else begin : g_unseeded
            assign load_nxt[i] = st_q[i];
        end

        if (i == K - 1) begin : g_top
            assign step_nxt[i] = fb;
        end else begin : g_body
            assign step_nxt[i] = st_q[i+1];
        end
    end

    always_comb begin
        case (op)
            OP_CLEAR: st_d = '0;
            OP_LOAD:  st_d = load_nxt;
            OP_STEP:  st_d = step_nxt;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages = st_q;

endmodule

// File: rtl/lfsr_reseed_dcmp.sv
module lfsr_reseed_dcmp
    import lfsr_dcmp_pkg::*;
#(
    parameter int           K    = 16,
    parameter int           S    = 10,
    parameter int           L    = 40,
    parameter logic [K-1:0] TAPS = K'(16'h002D)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic seed_valid,
    input  logic seed_bit,
    output logic scan_out,
    output logic scan_en,
    output logic done
);
    reg_op_e      reg_op;
    logic [K-1:0] lfsr_st;

    lfsr_dcmp_ctrl #(
        .S (S),
        .L (L)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .seed_valid (seed_valid),
        .op         (reg_op),
        .scan_en    (scan_en),
        .done       (done)
    );

    lfsr_dcmp_core #(
        .K    (K),
        .S    (S),
        .TAPS (TAPS)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .op       (reg_op),
        .seed_bit (seed_bit),
        .stages   (lfsr_st)
    );

    assign scan_out = lfsr_st[0];

endmodule

// File: rtl/lfsr_dcmp_chk.sv
module lfsr_dcmp_chk #(
    parameter int K = 16,
    parameter int S = 10,
    parameter int L = 40
) (
    input logic         clk,
    input logic         rst,
    input logic         seed_valid,
    input logic         scan_en,
    input logic         done,
    input logic [K-1:0] lfsr_st
);
    localparam int RW = $clog2(L + 2);

    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (scan_en) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R7: done only right after a shift cycle
    p_done_after_shift_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(scan_en));

    // R7: done lasts one cycle and the block is then idle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !scan_en));

    // R7: done and scan_en never overlap
    p_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(done && scan_en));

    // R5: shifting starts right after an accepted seed bit
    p_shift_after_seed_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_en) |-> $past(seed_valid));

    // R5: each shift run is exactly L cycles long
    p_shift_len_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(scan_en) && !$past(rst)) |-> (run_len == RW'(L)));

    // R4: unseeded stages are zero when shifting starts
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_en) |-> ((lfsr_st >> S) == '0));

endmodule

bind lfsr_reseed_dcmp lfsr_dcmp_chk #(
    .K (K),
    .S (S),
    .L (L)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .seed_valid (seed_valid),
    .scan_en    (scan_en),
    .done       (done),
    .lfsr_st    (lfsr_st)
);

// File: tb/lfsr_reseed_dcmp_test.sv
module lfsr_reseed_dcmp_test;
    localparam int          BK = 16;
    localparam int          BS = 10;
    localparam int          BL = 40;
    localparam logic [15:0] BT = 16'h002D;
    localparam int          SK = 3;
    localparam int          SS = 2;
    localparam int          SL = 7;
    localparam logic [2:0]  ST = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic seed_valid = 1'b0;
    logic seed_bit = 1'b0;
    logic sel = 1'b0;
    logic b_out, b_en, b_done, s_out, s_en, s_done;
    logic o_out, o_en, o_done;
    int   total = 0;
    int   bad = 0;

    always #5 clk = ~clk;

    lfsr_reseed_dcmp #(.K(BK), .S(BS), .L(BL), .TAPS(BT)) uut (
        .clk(clk), .rst(rst), .start(start & !sel),
        .seed_valid(seed_valid & !sel), .seed_bit(seed_bit),
        .scan_out(b_out), .scan_en(b_en), .done(b_done));

    lfsr_reseed_dcmp #(.K(SK), .S(SS), .L(SL), .TAPS(ST)) uut_small (
        .clk(clk), .rst(rst), .start(start & sel),
        .seed_valid(seed_valid & sel), .seed_bit(seed_bit),
        .scan_out(s_out), .scan_en(s_en), .done(s_done));

    assign o_out  = sel ? s_out  : b_out;
    assign o_en   = sel ? s_en   : b_en;
    assign o_done = sel ? s_done : b_done;

    function automatic logic [63:0] model(input logic [31:0] seed, input logic [31:0] taps,
                                          input int k, input int n);
        logic [31:0] st = seed;
        logic [63:0] r = '0;
        logic        fb;
        for (int j = 0; j < n; j++) begin
            r[j] = st[0];
            fb   = ^(st & taps);
            st   = (st >> 1) | (32'(fb) << (k - 1));
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_pat(input logic [31:0] seed, input bit gaps, input bit poke);
        int          sl = sel ? SS : BS;
        int          ll = sel ? SL : BL;
        int          k  = sel ? SK : BK;
        logic [31:0] tp = sel ? 32'(ST) : 32'(BT);
        logic [31:0] sd = seed & ((32'd1 << sl) - 1);
        logic [63:0] ex = model(sd, tp, k, ll);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seed_valid = poke;   // clear cycle: must be ignored (R3)
        seed_bit = 1'b1;
        @(negedge clk);
        seed_valid = 1'b0;
        for (int i = 0; i < sl; i++) begin
            if (gaps) begin
                repeat ($urandom_range(0, 2)) begin
                    seed_valid = 1'b0;
                    seed_bit = $urandom_range(0, 1);
                    @(negedge clk);
                    check(!o_en, "R3 stall keeps loading", o_en, 0);
                end
            end
            seed_valid = 1'b1;
            seed_bit = sd[i];
            @(negedge clk);
        end
        seed_valid = 1'b0;
        seed_bit = 1'b0;
        for (int j = 0; j < ll; j++) begin
            check(o_en == 1'b1, "R5 scan_en during shift", o_en, 1);
            check(o_out == ex[j], "R5 R6 R8 scan bit", o_out, ex[j]);
            check(!o_done, "R7 no done during shift", o_done, 0);
            if (poke) begin   // R2 R3 ignored during shift
                start = $urandom_range(0, 1);
                seed_valid = $urandom_range(0, 1);
                seed_bit = $urandom_range(0, 1);
            end
            @(negedge clk);
        end
        check(o_done && !o_en, "R7 done pulse", {o_done, o_en}, 2);
        start = 1'b0;
        seed_valid = 1'b0;
        @(negedge clk);
        check(!o_done && !o_en, "R7 idle after done", {o_done, o_en}, 0);
        @(negedge clk);
        check(!o_en, "R2 no restart from ignored start", o_en, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!b_en && !b_done && !b_out, "R1 reset state", {b_en, b_done, b_out}, 0);
        check(!s_en && !s_done && !s_out, "R1 reset state small", {s_en, s_done, s_out}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R9 model sanity against hand-worked streams
        check(model(32'd2, 32'd5, 3, 7) == 64'h72, "R9 model stream", 0, 0);
        check(model(32'd6, 32'd5, 3, 7) == 64'h2E, "R9 model example", 0, 0);

        sel = 1'b1;
        run_pat(32'd2, 1'b0, 1'b0);   // R9
        run_pat(32'd0, 1'b0, 1'b0);
        run_pat(32'd3, 1'b1, 1'b1);
        run_pat(32'd1, 1'b0, 1'b1);

        sel = 1'b0;
        run_pat(32'h3FF, 1'b0, 1'b0);
        run_pat(32'd0, 1'b0, 1'b0);   // R4 after all-ones leftovers
        run_pat(32'd1, 1'b1, 1'b0);
        for (int n = 0; n < 20; n++) begin
            run_pat($urandom, $urandom_range(0, 1), $urandom_range(0, 1));
        end

        // R1: reset during shift
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        for (int i = 0; i < BS; i++) begin
            seed_valid = 1'b1;
            seed_bit = 1'b1;
            @(negedge clk);
        end
        seed_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(b_en, "R5 shifting before reset", b_en, 1);
        rst = 1'b1;
        @(negedge clk);
        check(!b_en && !b_done && !b_out, "R1 mid-pattern reset", {b_en, b_done, b_out}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        run_pat(32'h155, 1'b1, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule